// File: doc/BRIEF.md
# Fibonacci Accumulator Sequencer

This block is a tiny 8-bit accumulator machine that produces the Fibonacci series with no program counter and no instruction decoding. A fixed state sequence moves one value per step across a single shared bus between a small read/write store, a data holding register, an accumulator and an adder. Each pass through the sequence produces the next term in the accumulator, and the two most recent terms are written back into two storage slots.

The machine advances on every clock in free-running mode. With the mode input low it advances by exactly one step for each press of a step button, which is synchronised and edge-detected inside the block. The accumulator drives the result output for bit-level display. When an addition carries out of 8 bits, the overflow output goes high and the sequence stops in an idle state until reset.

Top module: `fib_seq_core`

## Requirements
- R1: While reset is high the machine is set up: result reads 0, overflow reads 0, storage slot low holds 0, storage slot high holds 1, and the sequence restarts at its first step.
- R2: One iteration takes six steps, each a single bus transfer with at most one driver. (1) The low slot goes into the data register. (2) The data register goes into the accumulator. (3) The high slot goes into the data register. (4) The accumulator plus the data register goes into the accumulator. (5) The data register goes into the low slot. (6) The accumulator goes into the high slot. Result changes only at steps 2 and 4.
- R3: The adder works modulo 256. A carry out of bit 7 sets overflow, which then stays set. With default slots, the 13th addition gives 377, so result reads 121 with overflow high.
- R4: After overflow, result and overflow stay frozen under further clocks and step presses, in either mode, until reset.
- R5: With default slots, the results after successive additions are 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233.
- R6: With run mode high, one step completes per clock. The first addition completes on the 4th rising edge after reset is released, each later one 6 edges after the previous, and overflow is first seen after edge 76.
- R7: With run mode low, the machine does not advance without a press. One press, held for several clocks, advances exactly one step.
- R8: The 4-bit address space has 16 locations, but only addresses 0 to 7 hold data. Reads of 8 to 15 return 0 and writes there are dropped. With the high slot placed at address 9, result stays 0 and overflow stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 1 = advance every clock, 0 = advance on step presses |
| step_btn | input | 1 | Raw step button, asynchronous |
| result | output | DATA_W | Accumulator value for display |
| ovf | output | 1 | Sticky carry-out flag; sequence halted |

## Verification
The bench builds two copies of the block. The first uses the default parameters (slots at addresses 0 and 1, eight backed locations). It runs the series to the 8-bit carry in run mode, and it replays the step order against a model in step mode. The second copy moves the high slot to address 9. This makes the unbacked part of the address map observable at the ports, because an ignored write and a zero read hold the series at zero for good.

// File: rtl/fib_pkg.sv
package fib_pkg;

    typedef enum logic [2:0] {
        ST_LO_TO_MDR  = 3'd0,
        ST_MDR_TO_ACC = 3'd1,
        ST_HI_TO_MDR  = 3'd2,
        ST_SUM        = 3'd3,
        ST_MDR_TO_LO  = 3'd4,
        ST_ACC_TO_HI  = 3'd5,
        ST_IDLE       = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic ram_oe;
        logic mdr_oe;
        logic alu_oe;
        logic acc_oe;
        logic mdr_ld;
        logic acc_ld;
        logic ram_we;
        logic ovf_ld;
        logic sel_hi;
    } step_ctrl_t;

    function automatic step_ctrl_t decode_step(input seq_state_e st);
        step_ctrl_t c;
        c = '0;
        case (st)
            ST_LO_TO_MDR: begin
                c.ram_oe = 1'b1;
                c.mdr_ld = 1'b1;
            end
            ST_MDR_TO_ACC: begin
                c.mdr_oe = 1'b1;
                c.acc_ld = 1'b1;
            end
            ST_HI_TO_MDR: begin
                c.ram_oe = 1'b1;
                c.mdr_ld = 1'b1;
                c.sel_hi = 1'b1;
            end
            ST_SUM: begin
                c.alu_oe = 1'b1;
                c.acc_ld = 1'b1;
                c.ovf_ld = 1'b1;
            end
            ST_MDR_TO_LO: begin
                c.mdr_oe = 1'b1;
                c.ram_we = 1'b1;
            end
            ST_ACC_TO_HI: begin
                c.acc_oe = 1'b1;
                c.ram_we = 1'b1;
                c.sel_hi = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fib_step_ctrl.sv
module fib_step_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_mode,
    input  logic step_btn,
    output logic adv
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   press;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= step_btn;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], step_btn};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign press = sync_q[SYNC_STAGES-1] & ~prev_q;
    assign adv   = run_mode | press;
endmodule

// File: rtl/fib_sequencer.sv
module fib_sequencer
    import fib_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       carry,
    output seq_state_e state,
    output step_ctrl_t ctrl
);
    seq_state_e nxt;

    always_comb begin
        case (state)
            ST_LO_TO_MDR:  nxt = ST_MDR_TO_ACC;
            ST_MDR_TO_ACC: nxt = ST_HI_TO_MDR;
            ST_HI_TO_MDR:  nxt = ST_SUM;
            ST_SUM:        nxt = carry ? ST_IDLE : ST_MDR_TO_LO;
            ST_MDR_TO_LO:  nxt = ST_ACC_TO_HI;
            ST_ACC_TO_HI:  nxt = ST_LO_TO_MDR;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      state <= ST_LO_TO_MDR;
        else if (adv) state <= nxt;
    end

    assign ctrl = decode_step(state);
endmodule

// File: rtl/fib_ram.sv
module fib_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 8,
    parameter int LO     = 0,
    parameter int HI     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int              IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W:0] DEPTH_A = (ADDR_W+1)'(DEPTH);
    localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              backed;
    logic [IDX_W-1:0]  idx;

    assign backed = ({1'b0, addr} < DEPTH_A);
    assign idx    = addr[IDX_W-1:0];
    assign rdata  = backed ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == HI && i != LO) ? ONE : '0;
            end
        end else if (we && backed) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/fib_alu.sv
module fib_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry
);
    logic [DATA_W:0] wide;
    assign wide  = {1'b0, a} + {1'b0, b};
    assign sum   = wide[DATA_W-1:0];
    assign carry = wide[DATA_W];
endmodule

// File: rtl/fib_seq_core.sv
module fib_seq_core
    import fib_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int MEM_DEPTH   = 8,
    parameter int SLOT_LO     = 0,
    parameter int SLOT_HI     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_mode,
    input  logic              step_btn,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(SLOT_LO);
    localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(SLOT_HI);

    logic              adv;
    seq_state_e        seq_state;
    step_ctrl_t        ctrl;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] alu_sum;
    logic              alu_carry;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] acc_q;
    logic              ovf_q;
    logic [ADDR_W-1:0] addr;

    fib_step_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_step (
        .clk(clk), .rst(rst), .run_mode(run_mode), .step_btn(step_btn), .adv(adv)
    );

    fib_sequencer u_seq (
        .clk(clk), .rst(rst), .adv(adv), .carry(alu_carry),
        .state(seq_state), .ctrl(ctrl)
    );

    assign addr = ctrl.sel_hi ? ADDR_HI : ADDR_LO;

    fib_ram #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(MEM_DEPTH),
        .LO(SLOT_LO), .HI(SLOT_HI)
    ) u_ram (
        .clk(clk), .rst(rst), .addr(addr), .we(ctrl.ram_we & adv),
        .wdata(bus), .rdata(ram_rd)
    );

    fib_alu #(.DATA_W(DATA_W)) u_alu (
        .a(acc_q), .b(mdr_q), .sum(alu_sum), .carry(alu_carry)
    );

    assign bus = ({DATA_W{ctrl.ram_oe}} & ram_rd)
               | ({DATA_W{ctrl.mdr_oe}} & mdr_q)
               | ({DATA_W{ctrl.alu_oe}} & alu_sum)
               | ({DATA_W{ctrl.acc_oe}} & acc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mdr_q <= '0;
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (adv) begin
            if (ctrl.mdr_ld) mdr_q <= bus;
            if (ctrl.acc_ld) acc_q <= bus;
            if (ctrl.ovf_ld) ovf_q <= ovf_q | alu_carry;
        end
    end

    assign result = acc_q;
    assign ovf    = ovf_q;
endmodule

// File: rtl/fib_seq_chk.sv
module fib_seq_chk
    import fib_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              run_mode,
    input logic              adv,
    input seq_state_e        state,
    input step_ctrl_t        ctrl,
    input logic [DATA_W-1:0] result,
    input logic              ovf
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (result == '0 && !ovf && state == ST_LO_TO_MDR));

    // R2
    a_r2_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl.ram_oe, ctrl.mdr_oe, ctrl.alu_oe, ctrl.acc_oe}));

    // R3
    a_r3_ovf_after_sum: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(state) == ST_SUM);

    // R3
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R4
    a_r4_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> ($stable(result) && state == ST_IDLE));

    // R7
    a_r7_hold_without_press: assert property (@(posedge clk) disable iff (rst)
        (!run_mode && !adv) |=> $stable(state));
endmodule

bind fib_seq_core fib_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .run_mode(run_mode), .adv(adv),
    .state(seq_state), .ctrl(ctrl), .result(result), .ovf(ovf)
);

// File: tb/fib_seq_core_tb_top.sv
`timescale 1ns/1ps
module fib_seq_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_mode = 1'b1;
    logic       step_btn = 1'b0;
    logic [7:0] result;
    logic       ovf;
    logic [7:0] oob_result;
    logic       oob_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fib_seq_core dut_i (
        .clk(clk), .rst(rst), .run_mode(run_mode), .step_btn(step_btn),
        .result(result), .ovf(ovf)
    );

    fib_seq_core #(.SLOT_HI(9)) dut_oob (
        .clk(clk), .rst(rst), .run_mode(1'b1), .step_btn(1'b0),
        .result(oob_result), .ovf(oob_ovf)
    );

    // bench-side model state for step mode
    logic [7:0] m_lo, m_hi, m_acc, m_mdr;
    int         m_phase;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic run);
        @(negedge clk);
        run_mode = run;
        step_btn = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_lo = 8'd0; m_hi = 8'd1; m_acc = 8'd0; m_mdr = 8'd0; m_phase = 0;
    endtask

    task automatic press();
        step_btn = 1'b1;
        repeat (4) @(negedge clk);
        step_btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_step();
        case (m_phase)
            0: m_mdr = m_lo;
            1: m_acc = m_mdr;
            2: m_mdr = m_hi;
            3: m_acc = m_acc + m_mdr;
            4: m_lo  = m_mdr;
            default: m_hi = m_acc;
        endcase
        m_phase = (m_phase + 1) % 6;
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        check("R1 result after reset", result, 8'd0);
        check("R1 ovf after reset", {7'd0, ovf}, 8'd0);
        check("R1 oob result after reset", oob_result, 8'd0);
    endtask

    task automatic t_run_to_overflow();
        logic [7:0] fa, fb, fn;
        int k;
        int first_ovf;
        bit frozen_ok;
        do_reset(1'b1);
        fa = 8'd0; fb = 8'd1; k = 0; first_ovf = 0; frozen_ok = 1'b1;
        for (int n = 1; n <= 110; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (ovf && first_ovf == 0) first_ovf = n;
            if (n >= 4 && (n - 4) % 6 == 0 && k < 13) begin
                k++;
                fn = fa + fb;
                if (k < 13) begin
                    check($sformatf("R5 R6 term %0d", k), result, fn);
                    check("R3 no ovf before carry", {7'd0, ovf}, 8'd0);
                end else begin
                    check("R3 wrapped sum", result, 8'd121);
                    check("R3 ovf set on carry", {7'd0, ovf}, 8'd1);
                end
                fa = fb; fb = fn;
            end
            if (n > 76 && (result !== 8'd121 || ovf !== 1'b1)) frozen_ok = 1'b0;
        end
        check("R6 first ovf edge", 8'(first_ovf), 8'd76);
        check("R4 frozen in run mode", {7'd0, frozen_ok}, 8'd1);
        check("R8 oob result", oob_result, 8'd0);
        check("R8 oob ovf", {7'd0, oob_ovf}, 8'd0);
    endtask

    task automatic t_halt_manual();
        run_mode = 1'b0;
        press();
        press();
        check("R4 result frozen after presses", result, 8'd121);
        check("R4 ovf held", {7'd0, ovf}, 8'd1);
    endtask

    task automatic t_step_order();
        bit ok;
        do_reset(1'b0);
        ok = 1'b1;
        for (int s = 0; s < 18; s++) begin
            press();
            model_step();
            check($sformatf("R2 step %0d", s + 1), result, m_acc);
        end
        repeat (20) @(negedge clk);
        check("R7 idle without press", result, m_acc);
        press();
        model_step();
        check("R7 single advance after idle", result, m_acc);
        press();
        model_step();
        check("R7 single advance 2", result, m_acc);
        if (ovf !== 1'b0) ok = 1'b0;
        check("R3 no ovf in early steps", {7'd0, ok}, 8'd1);
    endtask

    initial begin
        t_reset();
        t_run_to_overflow();
        t_halt_manual();
        t_step_order();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule